// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Permission Controller

This block owns the status byte of a serial EEPROM and makes every decision on whether a write may proceed. Four things are tracked: a busy flag that is high while an internal write cycle runs; a write-enable latch, set and cleared by explicit commands; a three-bit lock selector that marks a region at the top of the array as read-only; and a pin-lock enable bit that, together with an active-low write-protect pin, freezes the status byte itself. The lock selector and the pin-lock enable stand in for nonvolatile cells and are held in ordinary registers. They load their parameter defaults at reset.

A command decoder upstream presents one-cycle command strobes. These are enable-writes, disable-writes, a status write carrying a data byte, and an array write carrying an address. The controller answers each array write or status write with a one-cycle grant or deny pulse. A grant is also the start signal for the external cycle timer. The timer pulses `cycle_done` when the internal cycle ends. A granted status write does not change the lock fields until that pulse arrives. The write-enable latch is cleared at the end of every granted cycle, so each write needs its own enable command.

The sequencer has three states. IDLE accepts commands. ARRAY_BUSY is entered from IDLE by a granted array write (transition `start_array`). STATUS_BUSY is entered from IDLE by a granted status write (transition `start_status`). Both busy states return to IDLE on `cycle_done` (transition `finish`). In STATUS_BUSY, `finish` also commits the pending lock fields.

Top module: `eeprom_status_ctrl`

## Requirements
- R1: The status byte is laid out as bit0 = busy, bit1 = write-enable latch, bits 4..2 = lock selector (bit4 most significant), bit7 = pin-lock enable, and bits 6..5 read 0. With default parameters it reads 0x00 after reset, and reset returns it to 0x00 even in the middle of a cycle.
- R2: An enable-writes strobe sets the latch and a disable-writes strobe clears it, visible one cycle later. Nothing else sets the latch. Both strobes are ignored while busy.
- R3: An array write or status write is granted only if the latch is 1 and busy is 0. Otherwise it is denied. Grant or deny pulses for exactly one cycle, in the cycle after the request. A denied request leaves the latch and the lock fields unchanged. If both requests arrive together, the array write wins and the status write is denied.
- R4: With the default geometry (2048 bytes, 16-byte pages), a lock selector value of 0 protects nothing. A value n from 1 to 6 protects the top min(16·2^(n−1), 1024) bytes. The value 7 protects the top half (addresses 0x400 and above). An array write to a protected address is denied. An array write just below the boundary is granted.
- R5: When the protect pin is low and pin-lock enable is 1, status writes are denied. When pin-lock enable is 0, the pin has no effect. The pin never affects array writes.
- R6: After a grant, busy reads 1 from the grant cycle until `cycle_done` is sampled. It reads 0 from the following cycle.
- R7: The write-enable latch clears at the end of each granted cycle.
- R8: A granted status write takes the lock selector from data bits 4..2 and pin-lock enable from data bit 7, and ignores the other data bits. The old values stay visible throughout the busy cycle. The new values appear in the cycle after `cycle_done`.
- R9: `cycle_done` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_enable | input | 1 | Strobe: set the write-enable latch |
| cmd_wr_disable | input | 1 | Strobe: clear the write-enable latch |
| cmd_status_wr | input | 1 | Strobe: request a status write |
| status_wr_data | input | 8 | Data byte for a status write |
| cmd_array_wr | input | 1 | Strobe: request an array write |
| array_wr_addr | input | ADDR_W | Byte address of the array write |
| wprot_n | input | 1 | Write-protect pin, active low |
| cycle_done | input | 1 | End-of-cycle pulse from the cycle timer |
| status_byte | output | 8 | Current status byte |
| array_grant | output | 1 | Array write granted; starts the cycle timer |
| array_deny | output | 1 | Array write refused |
| status_grant | output | 1 | Status write granted; starts the cycle timer |
| status_deny | output | 1 | Status write refused |

## Verification
A sequencer stuck in a busy state shows up at the next request as a deny where a grant was expected. It also shows at once as a busy bit that stays set in the status byte. A latch that is not cleared at `finish` is visible one cycle after `cycle_done`, as bit1 still set. A boundary that is off by one page, or a pin-lock term with the wrong polarity, changes the very next grant/deny pulse. A lock field committed at the start of a cycle instead of the end shows in the status byte during the busy window.

// File: rtl/eeps_pkg.sv
package eeps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ARRAY_BUSY  = 2'd1,
        ST_STATUS_BUSY = 2'd2
    } eeps_state_t;

    // positions inside the status byte; the reader decodes these
    localparam int SB_BUSY   = 0;
    localparam int SB_WEN    = 1;
    localparam int SB_LOCK_L = 2;
    localparam int SB_LOCK_H = 4;
    localparam int SB_PINEN  = 7;

    typedef struct packed {
        logic       pin_lock_en;
        logic [2:0] lock_sel;
    } eeps_nv_t;

    function automatic logic [7:0] eeps_pack(logic busy, logic wen, eeps_nv_t nv);
        logic [7:0] b;
        b                     = 8'h00;
        b[SB_BUSY]            = busy;
        b[SB_WEN]             = wen;
        b[SB_LOCK_H:SB_LOCK_L] = nv.lock_sel;
        b[SB_PINEN]           = nv.pin_lock_en;
        return b;
    endfunction

    function automatic eeps_nv_t eeps_unpack(logic [7:0] d);
        eeps_nv_t nv;
        nv.pin_lock_en = d[SB_PINEN];
        nv.lock_sel    = d[SB_LOCK_H:SB_LOCK_L];
        return nv;
    endfunction

endpackage

// File: rtl/eeps_region.sv
module eeps_region #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic [2:0]        lock_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;
    localparam int PAGE  = 1 << PAGE_W;

    // above[n]: address lies in the region selected by lock value n
    logic [7:0] above;

    assign above[0] = 1'b0;

    genvar g;
    generate
        for (g = 1; g < 8; g++) begin : g_level
            localparam int RAW  = (g == 7) ? HALF : (PAGE << (g - 1));
            localparam int SIZE = (RAW > HALF) ? HALF : RAW;
            localparam logic [ADDR_W:0] LOW = (ADDR_W + 1)'(DEPTH - SIZE);
            assign above[g] = ({1'b0, addr_i} >= LOW);
        end
    endgenerate

    assign locked_o = above[lock_sel_i];

endmodule

// File: rtl/eeps_fsm.sv
module eeps_fsm
    import eeps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_array_i,
    input  logic        req_status_i,
    input  logic        wen_i,
    input  logic        addr_locked_i,
    input  logic        pin_locked_i,
    input  logic        cycle_done_i,
    output eeps_state_t state_o,
    output logic        start_status_o,
    output logic        finish_o,
    output logic        array_grant_o,
    output logic        array_deny_o,
    output logic        status_grant_o,
    output logic        status_deny_o
);
    eeps_state_t state_q, state_d;
    logic idle, array_ok, status_ok, status_go, array_go;
    logic array_grant_q, array_deny_q, status_grant_q, status_deny_q;

    assign idle      = (state_q == ST_IDLE);
    assign array_ok  = idle & wen_i & ~addr_locked_i;
    assign status_ok = idle & wen_i & ~pin_locked_i;
    assign array_go  = req_array_i & array_ok;
    assign status_go = req_status_i & ~req_array_i & status_ok;
    assign finish_o  = ~idle & cycle_done_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (array_go)       state_d = ST_ARRAY_BUSY;
                else if (status_go) state_d = ST_STATUS_BUSY;
            end
            ST_ARRAY_BUSY:  if (cycle_done_i) state_d = ST_IDLE;
            ST_STATUS_BUSY: if (cycle_done_i) state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered response pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            array_grant_q  <= 1'b0;
            array_deny_q   <= 1'b0;
            status_grant_q <= 1'b0;
            status_deny_q  <= 1'b0;
        end else begin
            array_grant_q  <= array_go;
            array_deny_q   <= req_array_i & ~array_ok;
            status_grant_q <= status_go;
            status_deny_q  <= req_status_i & ~status_go;
        end
    end

    assign state_o        = state_q;
    assign start_status_o = status_go;
    assign array_grant_o  = array_grant_q;
    assign array_deny_o   = array_deny_q;
    assign status_grant_o = status_grant_q;
    assign status_deny_o  = status_deny_q;

    assert_grant_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (array_grant_q || status_grant_q) |-> ($past(state_q) == ST_IDLE && state_q != ST_IDLE));

    assert_grant_deny_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(array_grant_q && array_deny_q) && !(status_grant_q && status_deny_q));

    assert_finish_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> (state_q == ST_IDLE));

    assert_region_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        array_grant_q |-> !$past(addr_locked_i));

    assert_pin_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_grant_q |-> !$past(pin_locked_i));

endmodule

// File: rtl/eeps_regs.sv
module eeps_regs
    import eeps_pkg::*;
#(
    parameter logic [2:0] INIT_LOCK = 3'd0,
    parameter logic       INIT_PIN  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_i,
    input  logic       set_wen_i,
    input  logic       clr_wen_i,
    input  logic       start_status_i,
    input  logic [7:0] status_data_i,
    input  logic       finish_i,
    input  logic       commit_i,
    output logic       wen_o,
    output eeps_nv_t   nv_o
);
    logic     wen_q;
    eeps_nv_t nv_q, pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                    wen_q <= 1'b0;
        else if (finish_i)             wen_q <= 1'b0;
        else if (idle_i && clr_wen_i)  wen_q <= 1'b0;
        else if (idle_i && set_wen_i)  wen_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            nv_q   <= '{pin_lock_en: INIT_PIN, lock_sel: INIT_LOCK};
        end else begin
            if (start_status_i) pend_q <= eeps_unpack(status_data_i);
            if (commit_i)       nv_q   <= pend_q;
        end
    end

    assign wen_o = wen_q;
    assign nv_o  = nv_q;

    assert_nv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(nv_q));

    assert_wen_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> !wen_q);

    assert_wen_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i && !finish_i) |=> $stable(wen_q));

endmodule

// File: rtl/eeprom_status_ctrl.sv
module eeprom_status_ctrl
    import eeps_pkg::*;
#(
    parameter int         ADDR_W    = 11,
    parameter int         PAGE_W    = 4,
    parameter logic [2:0] INIT_LOCK = 3'd0,
    parameter logic       INIT_PIN  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_enable,
    input  logic              cmd_wr_disable,
    input  logic              cmd_status_wr,
    input  logic [7:0]        status_wr_data,
    input  logic              cmd_array_wr,
    input  logic [ADDR_W-1:0] array_wr_addr,
    input  logic              wprot_n,
    input  logic              cycle_done,
    output logic [7:0]        status_byte,
    output logic              array_grant,
    output logic              array_deny,
    output logic              status_grant,
    output logic              status_deny
);
    eeps_state_t state;
    eeps_nv_t    nv;
    logic        wen, addr_locked, pin_locked, start_status, finish, commit, idle;

    assign idle       = (state == ST_IDLE);
    assign pin_locked = ~wprot_n & nv.pin_lock_en;
    assign commit     = finish & (state == ST_STATUS_BUSY);

    eeps_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .lock_sel_i (nv.lock_sel),
        .addr_i     (array_wr_addr),
        .locked_o   (addr_locked)
    );

    eeps_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_array_i    (cmd_array_wr),
        .req_status_i   (cmd_status_wr),
        .wen_i          (wen),
        .addr_locked_i  (addr_locked),
        .pin_locked_i   (pin_locked),
        .cycle_done_i   (cycle_done),
        .state_o        (state),
        .start_status_o (start_status),
        .finish_o       (finish),
        .array_grant_o  (array_grant),
        .array_deny_o   (array_deny),
        .status_grant_o (status_grant),
        .status_deny_o  (status_deny)
    );

    eeps_regs #(.INIT_LOCK(INIT_LOCK), .INIT_PIN(INIT_PIN)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .idle_i         (idle),
        .set_wen_i      (cmd_wr_enable),
        .clr_wen_i      (cmd_wr_disable),
        .start_status_i (start_status),
        .status_data_i  (status_wr_data),
        .finish_i       (finish),
        .commit_i       (commit),
        .wen_o          (wen),
        .nv_o           (nv)
    );

    assign status_byte = eeps_pack(~idle, wen, nv);

    assert_busy_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (array_grant || status_grant) |-> status_byte[SB_BUSY]);

    assert_idle_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cycle_done && !cmd_array_wr && !cmd_status_wr) |=> !status_byte[SB_BUSY]);

endmodule

// File: tb/test_eeprom_status_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_status_ctrl;

    typedef struct packed {
        logic [2:0]  op;    // 0 none 1 enable 2 disable 3 status write 4 array write
        logic [7:0]  data;
        logic [10:0] addr;
        logic        pin;
        logic        grant;
        logic        deny;
        logic [7:0]  stat;  // status byte once the step is complete
        logic [3:0]  req;
    } vec_t;

    // R1 R2 R3 R4 R5 R7 R8 walked in order; expected bytes from the layout in R1
    localparam vec_t VECS [0:23] = '{
        '{3'd4, 8'h00, 11'h000, 1'b1, 1'b0, 1'b1, 8'h00, 4'd3}, // R3 no latch
        '{3'd3, 8'h9C, 11'h000, 1'b1, 1'b0, 1'b1, 8'h00, 4'd3},
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2}, // R2
        '{3'd2, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h00, 4'd2},
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h02, 4'd2},
        '{3'd3, 8'h84, 11'h000, 1'b1, 1'b1, 1'b0, 8'h84, 4'd8}, // R8 lock 1, pin en
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h86, 4'd2},
        '{3'd4, 8'h00, 11'h7F0, 1'b1, 1'b0, 1'b1, 8'h86, 4'd4}, // R4 top page
        '{3'd4, 8'h00, 11'h7EF, 1'b1, 1'b1, 1'b0, 8'h84, 4'd4},
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h86, 4'd2},
        '{3'd3, 8'h00, 11'h000, 1'b0, 1'b0, 1'b1, 8'h86, 4'd5}, // R5 pin lock
        '{3'd3, 8'h18, 11'h000, 1'b1, 1'b1, 1'b0, 8'h18, 4'd8}, // lock 6
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h1A, 4'd2},
        '{3'd4, 8'h00, 11'h600, 1'b1, 1'b0, 1'b1, 8'h1A, 4'd4},
        '{3'd4, 8'h00, 11'h5FF, 1'b1, 1'b1, 1'b0, 8'h18, 4'd4},
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h1A, 4'd2},
        '{3'd3, 8'h1C, 11'h000, 1'b0, 1'b1, 1'b0, 8'h1C, 4'd5}, // R5 pin low, enable 0
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h1E, 4'd2},
        '{3'd4, 8'h00, 11'h400, 1'b1, 1'b0, 1'b1, 8'h1E, 4'd4}, // lock 7 half
        '{3'd4, 8'h00, 11'h3FF, 1'b0, 1'b1, 1'b0, 8'h1C, 4'd5},
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h1E, 4'd2},
        '{3'd3, 8'h67, 11'h000, 1'b1, 1'b1, 1'b0, 8'h04, 4'd8}, // R8 stray bits
        '{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h06, 4'd2},
        '{3'd4, 8'h00, 11'h7EF, 1'b1, 1'b1, 1'b0, 8'h04, 4'd7}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_enable = 1'b0, cmd_wr_disable = 1'b0;
    logic        cmd_status_wr = 1'b0, cmd_array_wr = 1'b0;
    logic [7:0]  status_wr_data = 8'h00;
    logic [10:0] array_wr_addr = '0;
    logic        wprot_n = 1'b1, cycle_done = 1'b0;
    logic [7:0]  status_byte;
    logic        array_grant, array_deny, status_grant, status_deny;

    int checks = 0;
    int fails  = 0;
    logic [7:0] prev_stat = 8'h00;

    always #2.5 clk = ~clk;

    eeprom_status_ctrl i_eeprom_status_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_enable(cmd_wr_enable), .cmd_wr_disable(cmd_wr_disable),
        .cmd_status_wr(cmd_status_wr), .status_wr_data(status_wr_data),
        .cmd_array_wr(cmd_array_wr), .array_wr_addr(array_wr_addr),
        .wprot_n(wprot_n), .cycle_done(cycle_done),
        .status_byte(status_byte), .array_grant(array_grant), .array_deny(array_deny),
        .status_grant(status_grant), .status_deny(status_deny)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [7:0] d,
                         input logic [10:0] a, input logic pin);
        cmd_wr_enable  = (op == 3'd1);
        cmd_wr_disable = (op == 3'd2);
        cmd_status_wr  = (op == 3'd3);
        cmd_array_wr   = (op == 3'd4);
        status_wr_data = d;
        array_wr_addr  = a;
        wprot_n        = pin;
    endtask

    task automatic clear_cmds();
        cmd_wr_enable = 0; cmd_wr_disable = 0; cmd_status_wr = 0; cmd_array_wr = 0;
    endtask

    task automatic finish_cycle();
        cycle_done = 1'b1;
        @(negedge clk);
        cycle_done = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string r;
        r = $sformatf("R%0d[v%0d]", v.req, idx);
        @(negedge clk);
        drive(v.op, v.data, v.addr, v.pin);
        @(negedge clk);
        clear_cmds();
        chk((array_grant | status_grant) == v.grant, r, "grant", int'(array_grant | status_grant), int'(v.grant));
        chk((array_deny | status_deny) == v.deny, r, "deny", int'(array_deny | status_deny), int'(v.deny));
        if (v.grant) begin
            // R6 busy during the cycle, R8 old lock fields still shown
            chk(status_byte == (prev_stat | 8'h01), r, "busy status", int'(status_byte), int'(prev_stat | 8'h01));
            @(negedge clk);
            @(negedge clk);
            chk(status_byte == (prev_stat | 8'h01), "R6", "busy hold", int'(status_byte), int'(prev_stat | 8'h01));
            finish_cycle();
        end
        chk(status_byte == v.stat, r, "status", int'(status_byte), int'(v.stat));
        prev_stat = v.stat;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status_byte == 8'h00, "R1", "reset status", int'(status_byte), 8'h00);
        chk({array_grant, array_deny, status_grant, status_deny} == 4'b0, "R1", "reset pulses",
            int'({array_grant, array_deny, status_grant, status_deny}), 0);

        for (int i = 0; i < 24; i++) run_vec(VECS[i], i);

        // R3 R2 R7: requests during a busy cycle
        run_vec('{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h06, 4'd2}, 100);
        @(negedge clk); drive(3'd4, 8'h00, 11'h000, 1'b1);
        @(negedge clk); clear_cmds();
        chk(array_grant == 1'b1, "R3", "busy-test grant", int'(array_grant), 1);
        drive(3'd4, 8'h00, 11'h001, 1'b1);
        @(negedge clk); clear_cmds();
        chk(array_deny == 1'b1, "R3", "deny while busy", int'(array_deny), 1);
        drive(3'd2, 8'h00, 11'h000, 1'b1);
        @(negedge clk); clear_cmds();
        chk(status_byte == 8'h07, "R2", "disable ignored while busy", int'(status_byte), 8'h07);
        drive(3'd3, 8'h9C, 11'h000, 1'b1);
        @(negedge clk); clear_cmds();
        chk(status_deny == 1'b1, "R3", "status deny while busy", int'(status_deny), 1);
        chk(status_byte == 8'h07, "R3", "refused keeps fields", int'(status_byte), 8'h07);
        finish_cycle();
        chk(status_byte == 8'h04, "R7", "latch cleared at end", int'(status_byte), 8'h04);

        // R9 done while idle
        finish_cycle();
        @(negedge clk);
        chk(status_byte == 8'h04, "R9", "idle done ignored", int'(status_byte), 8'h04);

        // R3 simultaneous requests: array wins
        prev_stat = 8'h04;
        run_vec('{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h06, 4'd2}, 101);
        @(negedge clk);
        cmd_array_wr = 1; cmd_status_wr = 1; array_wr_addr = 11'h010; status_wr_data = 8'h9C;
        @(negedge clk); clear_cmds();
        chk(array_grant && status_deny && !status_grant, "R3", "array beats status",
            int'({array_grant, status_grant, status_deny}), 3'b101);
        finish_cycle();
        chk(status_byte == 8'h04, "R3", "status write dropped", int'(status_byte), 8'h04);

        // R4 lock 2: boundary 0x7E0
        prev_stat = 8'h04;
        run_vec('{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h06, 4'd2}, 102);
        run_vec('{3'd3, 8'h88, 11'h000, 1'b1, 1'b1, 1'b0, 8'h88, 4'd8}, 103);
        run_vec('{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h8A, 4'd2}, 104);
        run_vec('{3'd4, 8'h00, 11'h7E0, 1'b1, 1'b0, 1'b1, 8'h8A, 4'd4}, 105);
        run_vec('{3'd4, 8'h00, 11'h7DF, 1'b1, 1'b1, 1'b0, 8'h88, 4'd4}, 106);

        // R1 reset in the middle of a cycle
        run_vec('{3'd1, 8'h00, 11'h000, 1'b1, 1'b0, 1'b0, 8'h8A, 4'd2}, 107);
        @(negedge clk); drive(3'd4, 8'h00, 11'h000, 1'b1);
        @(negedge clk); clear_cmds();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_byte == 8'h00, "R1", "reset mid-cycle", int'(status_byte), 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule